// File: doc/BRIEF.md
# I2C Master Start/Stop Condition and Clock Timing Generator

This block is the condition-generating half of an I2C master. Software writes a small command word holding a bus-busy bit, a start/stop-control bit and a 4-bit clock select. With the control bit at 0, the bus-busy bit requests a start (or a repeated start, when the block already owns the bus) or a stop. The block then sequences its open-drain SDA and SCL pull-down enables. Each phase lasts half of the selected SCL period, counted in system clocks. A one-cycle done pulse marks the point where the condition is complete.

Separately, the block watches the sampled SDA and SCL levels to keep a bus-busy flag. Each line passes through a two-flop synchroniser. The flag sets on a falling SDA while SCL is high and clears on a rising SDA while SCL is high, whichever master drove the line. When the interface is switched to the clocked synchronous serial format, the bus-busy bit means nothing: such writes are dropped and the flag stays clear.

Top module: `i2c_master_cond`

## Requirements
- R1: While reset is asserted and immediately after it, sda_oe, scl_oe, bus_busy and cmd_done are all 0.
- R2: With cfg_div[3] = 0, the half period h (the length of each timed phase in system clocks) is 14, 20, 24, 32, 40, 50, 56 or 64 for cfg_div[2:0] = 0 to 7, giving SCL divisors 28, 40, 48, 64, 80, 100, 112 and 128.
- R3: With cfg_div[3] = 1, h is doubled to 28, 40, 48, 64, 80, 100, 112 or 128, giving divisors 56 to 256.
- R4: While idle, a write with cfg_busy = 1, cfg_ctl = 0 and cfg_sync = 0 starts the start sequence. From the next cycle, sda_oe = 1 with scl_oe = 0 for h cycles. Then scl_oe = 1 is added, and cmd_done is 1 for exactly that first cycle.
- R5: While the bus is held (both enables 1), the same write starts a repeated start. The block gives h cycles of (sda_oe 0, scl_oe 1), then h cycles of (0, 0), then h cycles of (1, 0), and ends held with a one-cycle cmd_done.
- R6: While held, a write with cfg_busy = 0 and cfg_ctl = 0 starts a stop. The block gives h cycles of (sda_oe 1, scl_oe 0), then both enables go to 0, with a one-cycle cmd_done.
- R7: A write with cfg_ctl = 1 only loads the clock select. The enables do not change and cmd_done stays 0.
- R8: A falling SDA while SCL is high sets bus_busy on the third clock edge after the line change.
- R9: A rising SDA while SCL is high clears bus_busy on the third clock edge after the line change.
- R10: While cfg_sync = 1, writes to the bus-busy bit start nothing, and bus_busy is 0 from the next cycle whatever the lines do.
- R11: A command written while a sequence is running is ignored, and so is a stop written while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Command/select write strobe |
| cfg_busy | input | 1 | Bus-busy bit of the write (1 start, 0 stop) |
| cfg_ctl | input | 1 | Start/stop-control bit; 1 means select-only write |
| cfg_div | input | 4 | SCL clock select |
| cfg_sync | input | 1 | 1 selects the clocked synchronous serial format |
| sda_in | input | 1 | Sampled SDA line level |
| scl_in | input | 1 | Sampled SCL line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| scl_oe | output | 1 | Pull SCL low when 1 |
| bus_busy | output | 1 | Bus occupied, as seen on the lines |
| cmd_done | output | 1 | One-cycle pulse when a condition completes |

## Verification
The assertions assume that sda_in and scl_in are the wired-AND of the block's own enables and of any other driver on the bus. They also assume that the clock select does not change while a sequence is running, since every phase reloads its count from the current select. The bench models the bus the same way, with pull-ups and optional external pull-downs. Any write it issues during a running sequence carries the same select, so the model's fixed phase length stays valid. The bench changes inputs only shortly after a rising edge, so each command is seen at exactly one edge.

// File: rtl/i2c_master_cond.sv
module i2c_master_cond #(
  parameter int CW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic       cfg_busy,
  input  logic       cfg_ctl,
  input  logic [3:0] cfg_div,
  input  logic       cfg_sync,
  input  logic       sda_in,
  input  logic       scl_in,
  output logic       sda_oe,
  output logic       scl_oe,
  output logic       bus_busy,
  output logic       cmd_done
);
  typedef enum logic [2:0] {IDLE, START, HELD, RS_LO, RS_HI, STOP} st_t;

  st_t           st;
  logic [3:0]    div_sel, div_now;
  logic [CW-1:0] cnt, base, half_now;
  logic          cmd_ok;

  assign div_now  = cfg_we ? cfg_div : div_sel;
  assign half_now = div_now[3] ? (base << 1) : base;
  assign cmd_ok   = cfg_we && !cfg_ctl && !cfg_sync;

  always_comb begin
    case (div_now[2:0])
      3'd0:    base = CW'(14);
      3'd1:    base = CW'(20);
      3'd2:    base = CW'(24);
      3'd3:    base = CW'(32);
      3'd4:    base = CW'(40);
      3'd5:    base = CW'(50);
      3'd6:    base = CW'(56);
      default: base = CW'(64);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      cnt      <= '0;
      div_sel  <= '0;
      cmd_done <= 1'b0;
    end else begin
      cmd_done <= 1'b0;
      if (cfg_we) div_sel <= cfg_div;
      case (st)
        IDLE: if (cmd_ok && cfg_busy) begin
          st  <= START;
          cnt <= half_now - CW'(1);
        end
        HELD: if (cmd_ok) begin
          st  <= cfg_busy ? RS_LO : STOP;
          cnt <= half_now - CW'(1);
        end
        default: begin
          if (cnt == '0) begin
            cnt      <= half_now - CW'(1);
            cmd_done <= (st == START) || (st == STOP);
            case (st)
              START:   st <= HELD;
              RS_LO:   st <= RS_HI;
              RS_HI:   st <= START;
              default: st <= IDLE;
            endcase
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
      endcase
    end
  end

  assign sda_oe = (st == START) || (st == HELD) || (st == STOP);
  assign scl_oe = (st == HELD) || (st == RS_LO);

  logic sda_s1, sda_s2, sda_q, scl_s1, scl_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {sda_s1, sda_s2, sda_q, scl_s1, scl_s2} <= 5'b11111;
      bus_busy <= 1'b0;
    end else begin
      sda_s1 <= sda_in;
      sda_s2 <= sda_s1;
      sda_q  <= sda_s2;
      scl_s1 <= scl_in;
      scl_s2 <= scl_s1;
      if (cfg_sync)                          bus_busy <= 1'b0;
      else if (scl_s2 && sda_q && !sda_s2)   bus_busy <= 1'b1;
      else if (scl_s2 && !sda_q && sda_s2)   bus_busy <= 1'b0;
    end
  end

  // R4
  scl_after_sda_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> sda_oe);
  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);
  // R6
  stop_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_oe) && !scl_oe) |-> $past(!scl_oe));
  // R7
  select_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_ctl && (st == IDLE || st == HELD)) |=> ($stable(sda_oe) && $stable(scl_oe) && !cmd_done));
  // R10
  sync_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sync |=> !bus_busy);
endmodule

// File: tb/tb_i2c_master_cond.sv
module tb_i2c_master_cond;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_busy = 1'b0, cfg_ctl = 1'b0, cfg_sync = 1'b0;
  logic [3:0] cfg_div = 4'd0;
  logic ext_sda = 1'b0, ext_scl = 1'b0;
  logic sda_in, scl_in, sda_oe, scl_oe, bus_busy, cmd_done;

  assign sda_in = ~(sda_oe | ext_sda);
  assign scl_in = ~(scl_oe | ext_scl);

  i2c_master_cond dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_busy(cfg_busy), .cfg_ctl(cfg_ctl),
    .cfg_div(cfg_div), .cfg_sync(cfg_sync), .sda_in(sda_in), .scl_in(scl_in),
    .sda_oe(sda_oe), .scl_oe(scl_oe), .bus_busy(bus_busy), .cmd_done(cmd_done)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_err = 0, cyc = 0;
  string cur_req = "R1";

  function automatic int halfp(input logic [3:0] d);
    int b;
    case (d[2:0])
      3'd0: b = 14; 3'd1: b = 20; 3'd2: b = 24; 3'd3: b = 32;
      3'd4: b = 40; 3'd5: b = 50; 3'd6: b = 56; default: b = 64;
    endcase
    return d[3] ? 2 * b : b;
  endfunction

  // captured pre-edge inputs
  logic c_rst = 1'b0, c_we = 1'b0, c_busy = 1'b0, c_ctl = 1'b0, c_sync = 1'b0;
  logic c_sda = 1'b1, c_scl = 1'b1;
  logic [3:0] c_div = 4'd0;

  // reference model state
  logic [2:0] evq[$];
  logic owned = 1'b0;
  logic e_sda = 1'b0, e_scl = 1'b0, e_done = 1'b0, e_busy = 1'b0;
  logic [3:0] m_div = 4'd0;
  logic a1 = 1'b1, a2 = 1'b1, a3 = 1'b1, b1 = 1'b1, b2 = 1'b1;

  task automatic push_n(input logic [2:0] v, input int n);
    for (int i = 0; i < n; i++) evq.push_back(v);
  endtask

  always @(posedge clk) begin
    if (!c_rst) begin
      evq.delete();
      owned = 1'b0; e_sda = 1'b0; e_scl = 1'b0; e_done = 1'b0; e_busy = 1'b0;
      m_div = 4'd0; a1 = 1'b1; a2 = 1'b1; a3 = 1'b1; b1 = 1'b1; b2 = 1'b1;
    end else begin
      int h;
      logic [2:0] e;
      if (c_sync) e_busy = 1'b0;
      else if (b2 && a3 && !a2) e_busy = 1'b1;
      else if (b2 && !a3 && a2) e_busy = 1'b0;
      a3 = a2; a2 = a1; a1 = c_sda; b2 = b1; b1 = c_scl;
      if (c_we) m_div = c_div;
      h = halfp(m_div);
      if (evq.size() == 0 && c_we && !c_ctl && !c_sync) begin
        if (!owned && c_busy) begin
          push_n(3'b100, h); push_n(3'b111, 1);
        end else if (owned && c_busy) begin
          push_n(3'b010, h); push_n(3'b000, h); push_n(3'b100, h); push_n(3'b111, 1);
        end else if (owned) begin
          push_n(3'b100, h); push_n(3'b001, 1);
        end
      end
      if (evq.size() > 0) begin
        e = evq.pop_front();
        e_sda = e[2]; e_scl = e[1]; e_done = e[0];
        if (e[0]) owned = e[2];
      end else begin
        e_sda = owned; e_scl = owned; e_done = 1'b0;
      end
    end
  end

  task automatic cmp(input string nm, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s cycle %0d %s: actual %b expected %b", cur_req, cyc, nm, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cmp("sda_oe", sda_oe, e_sda);
    cmp("scl_oe", scl_oe, e_scl);
    cmp("cmd_done", cmd_done, e_done);
    cmp("bus_busy", bus_busy, e_busy);
    c_rst = rst_n; c_we = cfg_we; c_busy = cfg_busy; c_ctl = cfg_ctl;
    c_sync = cfg_sync; c_div = cfg_div; c_sda = sda_in; c_scl = scl_in;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      n_err++;
      $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic b, input logic c, input logic [3:0] d);
    @(posedge clk); #2;
    cfg_we = 1'b1; cfg_busy = b; cfg_ctl = c; cfg_div = d;
    @(posedge clk); #2;
    cfg_we = 1'b0;
  endtask

  task automatic cmd_wait(input logic b, input logic [3:0] d);
    wr(b, 1'b0, d);
    idle(3 * halfp(d) + 6);
  endtask

  initial begin
    cur_req = "R1";
    idle(4);
    rst_n = 1'b1;
    idle(4);

    cur_req = "R7";
    wr(1'b1, 1'b1, 4'd3);
    idle(6);
    wr(1'b0, 1'b1, 4'd0);
    idle(6);

    cur_req = "R4";
    cmd_wait(1'b1, 4'd0);
    cur_req = "R8";
    idle(4);

    cur_req = "R7";
    wr(1'b0, 1'b1, 4'd9);
    idle(6);

    cur_req = "R5";
    cmd_wait(1'b1, 4'd5);

    cur_req = "R6";
    cmd_wait(1'b0, 4'd2);
    cur_req = "R9";
    idle(4);

    cur_req = "R11";
    cmd_wait(1'b0, 4'd1);
    wr(1'b1, 1'b0, 4'd1);
    idle(5);
    wr(1'b0, 1'b0, 4'd1);
    idle(80);
    wr(1'b1, 1'b0, 4'd1);
    idle(5);
    wr(1'b1, 1'b0, 4'd1);
    idle(80);
    cmd_wait(1'b0, 4'd1);

    for (int d = 0; d < 16; d++) begin
      cur_req = (d < 8) ? "R2" : "R3";
      cmd_wait(1'b1, 4'(d));
      cmd_wait(1'b0, 4'(d));
    end

    cur_req = "R8";
    ext_sda = 1'b1;
    idle(8);
    ext_scl = 1'b1;
    idle(4);
    ext_scl = 1'b0;
    idle(4);
    cur_req = "R9";
    ext_sda = 1'b0;
    idle(8);

    cur_req = "R10";
    cfg_sync = 1'b1;
    idle(3);
    ext_sda = 1'b1;
    idle(8);
    wr(1'b1, 1'b0, 4'd0);
    idle(40);
    ext_sda = 1'b0;
    idle(8);
    cfg_sync = 1'b0;
    idle(8);

    cur_req = "R1";
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule